// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single read or write transfers over a bus where one set of lines first carries the address and then the data. Each transfer moves through four clock states, T1 to T4. In T1 the address is put on the shared lines and the address latch enable is raised. From T2 to T4 the lines carry data, the transceiver is enabled and the read or write strobe is held low. A slow target pulls the ready input low during T2 to stretch the transfer with wait states between T3 and T4.

A client holds `req_i` with the address, the write data and the direction until it sees the latch enable. When the transfer completes, `done_o` pulses in T4, and for reads the data captured from the bus appears on `rdata_o`. An external master asks for the bus with `hold_i`. The sequencer first finishes any transfer in flight and then grants the bus with `hlda_o`. While granted, it stops driving the lines and keeps every strobe inactive.

Top module: `mbus_seq`

## Requirements
- R1: After reset the block is idle: `ale_o`=0, `dtr_o`=0, `den_n_o`=1, `rd_n_o`=1, `wr_n_o`=1, `bus_oe_o`=0, `done_o`=0 and `hlda_o`=0.
- R2: A transfer starts with one T1 cycle in which `ale_o`=1, `bus_oe_o`=1 and `bus_o` equals the requested address. `ale_o` is 0 in every other state.
- R3: For a read (`req_we_i`=0), `dtr_o` is 0 from T1 to T4. `rd_n_o` is 0 from T2 to T4, and `wr_n_o` stays 1. `bus_oe_o` is 0 after T1.
- R4: For a write (`req_we_i`=1), `dtr_o` is 1 from T1 to T4. `wr_n_o` is 0 from T2 to T4, and `rd_n_o` stays 1. `bus_oe_o`=1 and `bus_o` equals the write data from T2 to T4.
- R5: `den_n_o` is 0 from T2 through T4 for both directions, and 1 outside a transfer.
- R6: If `rdy_i` is 1 when sampled at the end of T2, T4 follows T3 directly, even if `rdy_i` is 0 during T3.
- R7: If `rdy_i` is 0 at the end of T2, one wait state follows T3 for each consecutive cycle, starting with T3, in which `rdy_i` is 0 at the clock edge. A transfer with n wait states lasts 4+n cycles.
- R8: If `rdy_i` is 0 at the end of T2 but 1 at the end of T3, no wait state is inserted.
- R9: On a read, `bus_i` is captured into `rdata_o` on the edge that leaves the last T3 or wait state. `rdata_o` keeps that value until the next read capture, and write transfers leave it unchanged.
- R10: `done_o` is a one-cycle pulse in T4.
- R11: When `hold_i` is raised during a transfer, the transfer completes normally and `hlda_o` rises in the cycle after T4. While `hlda_o`=1, `bus_oe_o`=0, all strobes are inactive and requests are ignored.
- R12: In idle, when `hold_i` and `req_i` are both present, the hold wins: `hlda_o` rises and no T1 occurs.
- R13: `hlda_o` falls one clock after `hold_i` is removed. A request pending at that point starts T1 in the same cycle that `hlda_o` is 0.
- R14: A request present in T4 starts its T1 in the very next cycle, with no idle cycle between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, held until `ale_o` is seen |
| req_we_i | input | 1 | Direction of the request: 1 write, 0 read |
| req_addr_i | input | DW | Address for the request |
| req_wdata_i | input | DW | Write data for the request |
| rdy_i | input | 1 | Target ready; 0 requests wait states |
| hold_i | input | 1 | External master asks for the bus |
| bus_i | input | DW | Value read from the shared lines |
| bus_o | output | DW | Value driven onto the shared lines |
| bus_oe_o | output | 1 | Output enable for `bus_o` |
| ale_o | output | 1 | Address latch enable, high in T1 |
| dtr_o | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| den_n_o | output | 1 | Transceiver enable, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| hlda_o | output | 1 | Bus granted to the external master |
| rdata_o | output | DW | Data captured by the last read |
| done_o | output | 1 | One-cycle pulse in T4 |

## Verification
Every output is decoded from the state register. A wrong state therefore shows at the ports in the same cycle: a strobe that is too long or too short, a latch enable outside T1, or a grant before T4 has passed. A wrong wait flag shows as a transfer whose length differs from 4+n, which the bench detects at the first cycle where `done_o` or the strobe pattern departs from the expected one. A capture on the wrong edge shows as `rdata_o` holding the decoy value that the bench puts on `bus_i` in every other cycle. The bench checks this in the cycle after T4.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5,
    S_HOLD = 3'd6
  } mbus_st_e;

  // true in any state of a running transfer
  function automatic logic st_in_xfer(mbus_st_e s);
    return (s == S_T1) || (s == S_T2) || (s == S_T3) || (s == S_TW) || (s == S_T4);
  endfunction

  // true where data strobes and transceiver enable are active
  function automatic logic st_data_phase(mbus_st_e s);
    return (s == S_T2) || (s == S_T3) || (s == S_TW) || (s == S_T4);
  endfunction

  // state after T3 or a wait state, given the flag sampled in T2
  function automatic mbus_st_e st_after_t3(logic wait_q, logic rdy, mbus_st_e s);
    if (s == S_TW) return rdy ? S_T4 : S_TW;
    return (wait_q && !rdy) ? S_TW : S_T4;
  endfunction

  // state chosen when the bus is free to start something new
  function automatic mbus_st_e st_pick(logic hold, logic req);
    if (hold) return S_HOLD;
    if (req)  return S_T1;
    return S_IDLE;
  endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_i,
  input  logic     rdy_i,
  input  logic     hold_i,
  output mbus_st_e st_o,
  output logic     latch_o,
  output logic     cap_o
);

  mbus_st_e st_q, st_d;
  logic     wait_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:      st_d = st_pick(hold_i, req_i);
      S_T1:        st_d = S_T2;
      S_T2:        st_d = S_T3;
      S_T3, S_TW:  st_d = st_after_t3(wait_q, rdy_i, st_q);
      S_T4:        st_d = st_pick(hold_i, req_i);
      S_HOLD:      st_d = st_pick(hold_i, req_i);
      default:     st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      wait_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_T2) wait_q <= !rdy_i;
    end
  end

  assign st_o    = st_q;
  assign latch_o = (st_d == S_T1);
  assign cap_o   = ((st_q == S_T3) || (st_q == S_TW)) && (st_d == S_T4);

  // R6
  no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T2 && rdy_i) |=> (st_q == S_T3) ##1 (st_q == S_T4));

  // R7
  tw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TW) |-> ($past(st_q) == S_T3 || $past(st_q) == S_TW));

  // R11
  hold_after_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T4 && hold_i) |=> (st_q == S_HOLD));

  // R13
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD && !hold_i) |=> (st_q != S_HOLD));

endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
(
  input  mbus_st_e st_i,
  input  logic     we_i,
  output logic     ale_o,
  output logic     dtr_o,
  output logic     den_n_o,
  output logic     rd_n_o,
  output logic     wr_n_o,
  output logic     oe_o,
  output logic     sel_addr_o,
  output logic     done_o,
  output logic     hlda_o
);

  logic data_ph;

  always_comb begin
    data_ph    = st_data_phase(st_i);
    ale_o      = (st_i == S_T1);
    sel_addr_o = (st_i == S_T1);
    dtr_o      = st_in_xfer(st_i) && we_i;
    den_n_o    = !data_ph;
    rd_n_o     = !(data_ph && !we_i);
    wr_n_o     = !(data_ph && we_i);
    oe_o       = (st_i == S_T1) || (data_ph && we_i);
    done_o     = (st_i == S_T4);
    hlda_o     = (st_i == S_HOLD);
  end

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_i,
  input  logic          cap_i,
  input  logic          sel_addr_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] bus_i,
  output logic          we_o,
  output logic [DW-1:0] bus_o,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] addr_q, wdata_q, rdata_q;
  logic          we_q;
  logic          cap_rd;

  assign cap_rd = cap_i && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (latch_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        we_q    <= req_we_i;
      end
      if (cap_rd) rdata_q <= bus_i;
    end
  end

  assign we_o    = we_q;
  assign bus_o   = sel_addr_i ? addr_q : (we_q ? wdata_q : '0);
  assign rdata_o = rdata_q;

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rd |=> $stable(rdata_q));

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          rdy_i,
  input  logic          hold_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          ale_o,
  output logic          dtr_o,
  output logic          den_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          hlda_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  mbus_st_e st;
  logic     latch_evt, cap_evt, sel_addr, cyc_we;

  mbus_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .rdy_i   (rdy_i),
    .hold_i  (hold_i),
    .st_o    (st),
    .latch_o (latch_evt),
    .cap_o   (cap_evt)
  );

  mbus_decode u_dec (
    .st_i       (st),
    .we_i       (cyc_we),
    .ale_o      (ale_o),
    .dtr_o      (dtr_o),
    .den_n_o    (den_n_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .oe_o       (bus_oe_o),
    .sel_addr_o (sel_addr),
    .done_o     (done_o),
    .hlda_o     (hlda_o)
  );

  mbus_datapath #(.DW(DW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_i     (latch_evt),
    .cap_i       (cap_evt),
    .sel_addr_i  (sel_addr),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .bus_i       (bus_i),
    .we_o        (cyc_we),
    .bus_o       (bus_o),
    .rdata_o     (rdata_o)
  );

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  hlda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_o |-> (!bus_oe_o && rd_n_o && wr_n_o && den_n_o && !ale_o));

  // R12
  hold_no_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && hold_i) |=> (hlda_o && !ale_o));

endmodule

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0, req_we_i = 1'b0, rdy_i = 1'b1, hold_i = 1'b0;
  logic [DW-1:0] req_addr_i = '0, req_wdata_i = '0, bus_i = '0;
  logic [DW-1:0] bus_o, rdata_o;
  logic          bus_oe_o, ale_o, dtr_o, den_n_o, rd_n_o, wr_n_o, hlda_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic [DW-1:0] last_rd = '0;

  always #4 clk = ~clk;

  mbus_seq #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .rdy_i(rdy_i),
    .hold_i(hold_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .ale_o(ale_o), .dtr_o(dtr_o), .den_n_o(den_n_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .hlda_o(hlda_o), .rdata_o(rdata_o), .done_o(done_o)
  );

  // {ale, dtr, den_n, rd_n, wr_n, oe, done, hlda}
  function automatic logic [7:0] ctl_now();
    return {ale_o, dtr_o, den_n_o, rd_n_o, wr_n_o, bus_oe_o, done_o, hlda_o};
  endfunction

  function automatic logic [7:0] ctl_exp(int k, int len, logic we, logic hl);
    logic [7:0] v;
    if (hl)            v = 8'b0_0_1_1_1_0_0_1;
    else if (k < 0)    v = 8'b0_0_1_1_1_0_0_0;
    else if (k == 0)   v = {1'b1, we, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    else               v = {1'b0, we, 1'b0, we, !we, we, (k == len - 1), 1'b0};
    return v;
  endfunction

  function automatic logic [DW-1:0] rd_val(logic [DW-1:0] a, int n);
    return a ^ (16'h5A00 + 16'(n * 16'h0111));
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected < 100000", cyc);
      summary();
    end
  end

  // one transfer from idle; pat 0: n waits, 1: ready low only in T2 (R8),
  // 2: ready low only in T3 (R6); hmid raises hold in T2 (R11)
  task automatic xfer(logic we, logic [DW-1:0] a, logic [DW-1:0] wd, int n, int pat, logic hmid);
    int w, len;
    logic [DW-1:0] dv;
    w   = (pat == 0) ? n : 0;
    len = 4 + w;
    dv  = rd_val(a, n);
    @(negedge clk);
    req_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = wd; rdy_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(ctl_now() == ctl_exp(0, len, we, 1'b0), "R2 T1 controls", 32'(ctl_now()), 32'(ctl_exp(0, len, we, 1'b0)));
    chk(bus_o == a, "R2 address on bus", 32'(bus_o), 32'(a));
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      chk(ctl_now() == ctl_exp(k, len, we, 1'b0), we ? "R4 R5 R7 R10 write phase" : "R3 R5 R7 R10 read phase",
          32'(ctl_now()), 32'(ctl_exp(k, len, we, 1'b0)));
      if (we) chk(bus_o == wd, "R4 write data on bus", 32'(bus_o), 32'(wd));
      if (pat == 0)      rdy_i = !(n > 0 && k >= 1 && k <= n + 1);
      else if (pat == 1) rdy_i = !(k == 1);
      else               rdy_i = !(k == 2);
      if (k == 1 && hmid) hold_i = 1'b1;
      bus_i = (k == 2 + w) ? dv : ~dv;
    end
    @(negedge clk);
    rdy_i = 1'b1;
    chk(ctl_now() == ctl_exp(-1, len, we, hmid), hmid ? "R11 grant after T4" : "R10 idle after T4",
        32'(ctl_now()), 32'(ctl_exp(-1, len, we, hmid)));
    if (!we) last_rd = dv;
    chk(rdata_o == last_rd, "R9 captured read data", 32'(rdata_o), 32'(last_rd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ctl_now() == 8'b0_0_1_1_1_0_0_0, "R1 reset state", 32'(ctl_now()), 32'h38);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_now() == 8'b0_0_1_1_1_0_0_0, "R1 idle after reset", 32'(ctl_now()), 32'h38);

    // sweep of direction, wait count and address (R2 R3 R4 R5 R7 R9 R10)
    for (int we = 0; we < 2; we++)
      for (int n = 0; n < 5; n++)
        for (int i = 0; i < 2; i++)
          xfer(we[0], 16'(16'h1357 * (n + 1) + i * 16'h0F0F), 16'(16'hC0DE ^ (n * 16'h0101 + i)), n, 0, 1'b0);

    // R8 ready low in T2 only; R6 ready low in T3 only
    xfer(1'b0, 16'hA5A5, 16'h0, 3, 1, 1'b0);
    xfer(1'b0, 16'h3C3C, 16'h0, 3, 2, 1'b0);

    // R11: hold during a read, requests ignored while granted
    xfer(1'b0, 16'h2468, 16'h0, 1, 0, 1'b1);
    req_i = 1'b1; req_we_i = 1'b1; req_addr_i = 16'h7777; req_wdata_i = 16'h8888;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(ctl_now() == ctl_exp(-1, 4, 1'b0, 1'b1), "R11 request ignored in hold", 32'(ctl_now()), 32'h39);
    end
    // R13: release, pending request enters T1 as grant drops
    hold_i = 1'b0;
    @(negedge clk);
    chk(ctl_now() == ctl_exp(0, 4, 1'b1, 1'b0), "R13 grant drop and T1", 32'(ctl_now()), 32'(ctl_exp(0, 4, 1'b1, 1'b0)));
    chk(bus_o == 16'h7777, "R13 pending address", 32'(bus_o), 32'h7777);
    req_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(ctl_now() == 8'b0_0_1_1_1_0_0_0, "R13 idle after pending transfer", 32'(ctl_now()), 32'h38);
    chk(rdata_o == last_rd, "R9 write leaves read data", 32'(rdata_o), 32'(last_rd));

    // R12: hold and request together in idle
    hold_i = 1'b1; req_i = 1'b1; req_we_i = 1'b0;
    @(negedge clk);
    chk(ctl_now() == ctl_exp(-1, 4, 1'b0, 1'b1), "R12 hold wins over request", 32'(ctl_now()), 32'h39);
    req_i = 1'b0; hold_i = 1'b0;
    @(negedge clk);
    chk(ctl_now() == 8'b0_0_1_1_1_0_0_0, "R13 idle after release", 32'(ctl_now()), 32'h38);

    // R14: back-to-back transfers
    req_i = 1'b1; req_we_i = 1'b1; req_addr_i = 16'h1111; req_wdata_i = 16'h2222;
    @(negedge clk);
    chk(ale_o == 1'b1, "R14 first T1", 32'(ale_o), 32'h1);
    req_addr_i = 16'h3333;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b1, "R14 first T4", 32'(done_o), 32'h1);
    @(negedge clk);
    chk(ale_o == 1'b1 && bus_o == 16'h3333, "R14 second T1 without gap", 32'({ale_o, bus_o}), 32'h13333);
    req_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(ctl_now() == 8'b0_0_1_1_1_0_0_0, "R14 idle after second", 32'(ctl_now()), 32'h38);

    summary();
  end

endmodule